// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Variable Page Runs

The block translates virtual addresses to physical addresses through a small, fully associative table. Every entry holds a virtual page tag, a physical page number, a valid bit and a two-bit run-size code. The run-size code lets one entry cover a naturally aligned run of 1, 8, 64 or 512 consecutive 8-Kbyte base pages. The low page-number bits inside the run are ignored in the tag compare. For a hit, those same bits are copied from the virtual address into the physical page number.

A lookup is presented with `lk_valid` and `lk_va`. One clock later the registered outputs report whether an entry matched, the translated address, and a flag that is set when more than one valid entry matched. When several entries match, the entry with the lowest index wins. Software-side logic installs entries through a one-cycle write port that addresses an entry by index. A single invalidate-all input clears every valid bit in one cycle. The number of entries is a parameter: 64 suits a data-side buffer and 48 suits an instruction-side buffer.

Top module: `xlat_buffer`

## Requirements
- R1: After synchronous reset every entry is invalid and `rsp_valid`, `rsp_hit` and `rsp_multi` are 0; a lookup issued just after reset misses.
- R2: A lookup presented with `lk_valid` high at a clock edge is answered by `rsp_valid`=1 right after that edge; without a request `rsp_valid` is 0 in the following cycle.
- R3: The low 13 address bits (the byte offset within an 8-Kbyte page) appear unchanged on `rsp_pa[12:0]` for every hit.
- R4: The run-size code selects how many low page-number bits are left out of the tag compare: code 0 leaves out 0 bits, code 1 leaves out 3, code 2 leaves out 6 and code 3 leaves out 9. The entry therefore covers 1, 8, 64 or 512 pages.
- R5: On a hit, the physical page bits that sit under the run-size mask are taken from the virtual page number. The stored physical and tag bits in those positions have no effect.
- R6: A write stores tag, physical page, run-size code and valid bit at `wr_idx` in one cycle. A lookup in the cycle after the write sees the new contents. A lookup in the same cycle as the write sees the old contents. Writing with `wr_valid`=0 removes the entry.
- R7: `inv_all` clears the valid bit of every entry in one cycle, so every later lookup misses until new entries are written.
- R8: When `inv_all` and a write occur in the same cycle, the written entry takes the written valid bit and every other entry is cleared.
- R9: When two or more valid entries match, `rsp_multi` is 1, `rsp_hit` is 1 and `rsp_pa` comes from the lowest-index matching entry. With exactly one match, `rsp_multi` is 0.
- R10: On a miss `rsp_hit` and `rsp_multi` are 0; the value of `rsp_pa` on a miss is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Lookup answer present (one cycle after request) |
| rsp_hit | output | 1 | At least one valid entry matched |
| rsp_multi | output | 1 | More than one valid entry matched |
| rsp_pa | output | PA_W | Translated physical address |
| wr_en | input | 1 | Install one entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_vpn | input | VA_W-13 | Virtual page tag to store |
| wr_ppn | input | PA_W-13 | Physical page number to store |
| wr_gran | input | 2 | Run-size code (0..3 = 1, 8, 64, 512 pages) |
| inv_all | input | 1 | Clear every valid bit |

## Verification
Two pairs of functions can occur in the same cycle. The first pair is a write and a lookup that both target the same page. The bench issues both at one edge and expects a miss, because the lookup reads the old table. It then repeats the lookup alone and expects a hit. The second pair is invalidate-all together with a write. The bench raises both at one edge, then checks that the written page hits and that a page installed earlier now misses.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int PAGE_OFS_W = 13;
  localparam int GRAN_STEP  = 3;

  typedef enum logic [1:0] {
    RUN_1   = 2'd0,
    RUN_8   = 2'd1,
    RUN_64  = 2'd2,
    RUN_512 = 2'd3
  } run_code_e;

  function automatic int run_lsbs(input logic [1:0] code);
    return int'(code) * GRAN_STEP;
  endfunction

endpackage

// File: rtl/xlat_cell.sv
module xlat_cell
  import xlat_pkg::*;
#(
  parameter int VPN_W = 30,
  parameter int PPN_W = 27,
  parameter int IDX_W = 6,
  parameter int SLOT  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [1:0]       wr_gran,
  input  logic [VPN_W-1:0] q_vpn,
  output logic             match,
  output logic [PPN_W-1:0] xppn
);

  logic             vld;
  logic [VPN_W-1:0] tag;
  logic [PPN_W-1:0] ppn;
  logic [1:0]       gran;
  logic             sel;
  logic [VPN_W-1:0] vmask;
  logic [PPN_W-1:0] pmask;

  assign sel = wr_en && (wr_idx == IDX_W'(SLOT));

  // valid bit: reset, global clear, then per-slot write overrides
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else begin
      if (inv_all) vld <= 1'b0;
      if (sel)     vld <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (sel) begin
      tag  <= wr_vpn;
      ppn  <= wr_ppn;
      gran <= wr_gran;
    end
  end

  always_comb begin
    vmask = {VPN_W{1'b1}} << run_lsbs(gran);
    pmask = {PPN_W{1'b1}} << run_lsbs(gran);
    match = vld && (((q_vpn ^ tag) & vmask) == '0);
    xppn  = (ppn & pmask) | (PPN_W'(q_vpn) & ~pmask);
  end

  a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
    sel |=> (vld == $past(wr_valid)) && (tag == $past(wr_vpn)) && (ppn == $past(wr_ppn)));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !sel) |=> !vld);

  a_r8_write_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (inv_all && sel) |=> (vld == $past(wr_valid)));

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic             multi,
  output logic [IDX_W-1:0] first
);

  always_comb begin
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) first = IDX_W'(i);
    end
    any   = |hits;
    multi = $countones(hits) > 1;
  end

  a_r9_pick_is_set: assert property (@(posedge clk) disable iff (rst)
    any |-> hits[first]);

  a_r9_pick_lowest: assert property (@(posedge clk) disable iff (rst)
    any |-> ((hits & ((N'(1) << first) - N'(1))) == '0));

  a_r9_multi_needs_any: assert property (@(posedge clk) disable iff (rst)
    multi |-> any);

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 43,
  parameter int PA_W    = 40,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W  = VA_W - PAGE_OFS_W,
  localparam int PPN_W  = PA_W - PAGE_OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_multi,
  output logic [PA_W-1:0]  rsp_pa,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [1:0]       wr_gran,
  input  logic             inv_all
);

  logic [VPN_W-1:0] q_vpn;
  logic [ENTRIES-1:0] hits;
  logic [PPN_W-1:0] xppn [ENTRIES];
  logic             any, multi;
  logic [IDX_W-1:0] first;
  logic [PPN_W-1:0] win_ppn;

  assign q_vpn = lk_va[VA_W-1:PAGE_OFS_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    xlat_cell #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .SLOT(g)
    ) u_cell (
      .clk(clk), .rst(rst), .inv_all(inv_all),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
      .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_gran(wr_gran),
      .q_vpn(q_vpn), .match(hits[g]), .xppn(xppn[g])
    );
  end

  xlat_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .hits(hits),
    .any(any), .multi(multi), .first(first)
  );

  assign win_ppn = xppn[first];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any;
      rsp_multi <= lk_valid && multi;
      rsp_pa    <= {win_ppn, lk_va[PAGE_OFS_W-1:0]};
    end
  end

  a_r2_answer_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  a_r10_no_flags_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_multi));

  a_r9_multi_is_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_hit);

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && any) |=> (rsp_pa[PAGE_OFS_W-1:0] == $past(lk_va[PAGE_OFS_W-1:0])));

endmodule

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 64;
  localparam int VA_W = 43;
  localparam int PA_W = 40;
  localparam int IDX_W = 6;
  localparam int VPN_W = 30;
  localparam int PPN_W = 27;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0;
  logic [VA_W-1:0]  lk_va = '0;
  logic             rsp_valid, rsp_hit, rsp_multi;
  logic [PA_W-1:0]  rsp_pa;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic             wr_valid = 1'b0;
  logic [VPN_W-1:0] wr_vpn = '0;
  logic [PPN_W-1:0] wr_ppn = '0;
  logic [1:0]       wr_gran = '0;
  logic             inv_all = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  logic s_valid, s_hit, s_multi;
  logic [PA_W-1:0] s_pa;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_buffer #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi), .rsp_pa(rsp_pa),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vpn(wr_vpn),
    .wr_ppn(wr_ppn), .wr_gran(wr_gran), .inv_all(inv_all)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [VPN_W-1:0] vpn,
                     input logic [PPN_W-1:0] ppn, input logic [1:0] g, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_gran = g; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [12:0] ofs);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = {vpn, ofs};
    @(posedge clk); #1;
    s_valid = rsp_valid; s_hit = rsp_hit; s_multi = rsp_multi; s_pa = rsp_pa;
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [VPN_W-1:0] vpn,
                            input logic [12:0] ofs, input logic [PPN_W-1:0] ppn, input logic m);
    look(vpn, ofs);
    check({tag, " valid"}, 64'(s_valid), 64'd1);
    check({tag, " hit"}, 64'(s_hit), 64'd1);
    check({tag, " multi"}, 64'(s_multi), 64'(m));
    check({tag, " pa"}, 64'(s_pa), 64'({ppn, ofs}));
  endtask

  task automatic expect_miss(input string tag, input logic [VPN_W-1:0] vpn);
    look(vpn, 13'h0);
    check({tag, " miss hit"}, 64'(s_hit), 64'd0);
    check({tag, " miss multi"}, 64'(s_multi), 64'd0);
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 rsp_hit after reset", 64'(rsp_hit), 64'd0);
    expect_miss("R1 empty table", 30'h0);
    @(negedge clk); @(posedge clk); #1;
    check("R2 idle rsp_valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_single_page;
    put(5, 30'h0123456, 27'h00ABCD, 2'd0, 1'b1);
    expect_hit("R3 R4 single page", 30'h0123456, 13'h1A5, 27'h00ABCD, 1'b0);
    expect_miss("R4 R10 neighbour page", 30'h0123457);
  endtask

  task automatic t_runs;
    put(10, 30'h0200008, 27'h0004440, 2'd1, 1'b1);
    expect_hit("R4 R5 run of 8", 30'h020000D, 13'h1FFF, 27'h0004445, 1'b0);
    expect_miss("R4 past run of 8", 30'h0200010);
    put(20, 30'h0300055, 27'h0008011, 2'd2, 1'b1);
    expect_hit("R5 run of 64 masked bits", 30'h030006A, 13'h0007, 27'h000802A, 1'b0);
    expect_miss("R4 past run of 64", 30'h0300080);
    put(63, 30'h0400000, 27'h0010000, 2'd3, 1'b1);
    expect_hit("R4 R5 run of 512", 30'h04001FF, 13'h0ACE, 27'h00101FF, 1'b0);
    expect_miss("R4 past run of 512", 30'h0400200);
  endtask

  task automatic t_multi;
    put(30, 30'h0500001, 27'h0000111, 2'd0, 1'b1);
    put(40, 30'h0500000, 27'h0002228, 2'd1, 1'b1);
    expect_hit("R9 two matches lowest wins", 30'h0500001, 13'h0010, 27'h0000111, 1'b1);
    expect_hit("R9 single match", 30'h0500003, 13'h0020, 27'h000222B, 1'b0);
  endtask

  task automatic t_write_lookup_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd7; wr_vpn = 30'h0600000; wr_ppn = 27'h0000777;
    wr_gran = 2'd0; wr_valid = 1'b1;
    lk_valid = 1'b1; lk_va = {30'h0600000, 13'h0};
    @(posedge clk); #1;
    check("R6 same-cycle lookup sees old", 64'(rsp_hit), 64'd0);
    wr_en = 1'b0; lk_valid = 1'b0;
    expect_hit("R6 next-cycle lookup sees new", 30'h0600000, 13'h0042, 27'h0000777, 1'b0);
    put(7, 30'h0600000, 27'h0000777, 2'd0, 1'b0);
    expect_miss("R6 write with valid low removes", 30'h0600000);
  endtask

  task automatic t_invalidate;
    @(negedge clk);
    inv_all = 1'b1;
    wr_en = 1'b1; wr_idx = 6'd12; wr_vpn = 30'h0700000; wr_ppn = 27'h0000ABC;
    wr_gran = 2'd0; wr_valid = 1'b1;
    @(negedge clk);
    inv_all = 1'b0; wr_en = 1'b0;
    expect_hit("R8 write survives clear", 30'h0700000, 13'h0005, 27'h0000ABC, 1'b0);
    expect_miss("R8 R7 other entry cleared", 30'h0123456);
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    expect_miss("R7 clear removes all", 30'h0700000);
    expect_miss("R7 run entry gone", 30'h04001FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    t_reset;
    t_single_page;
    t_runs;
    t_multi;
    t_write_lookup_same_cycle;
    t_invalidate;
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule